// File: doc/BRIEF.md
# I2C Target Port Expander

This block is an I2C bus target that gives a host one 8-bit parallel port with no register file behind it. The bus data maps straight onto the port. A write transaction puts the first data byte onto the port pins. A read transaction returns the level present on the port input pins. SCL and SDA are oversampled by a faster system clock. The block finds start, repeated start and stop conditions and counts bits on the synchronized SCL edges.

The 7-bit address is a fixed four-bit prefix followed by three strap inputs. A matching address is acknowledged. After a write address, the first complete and acknowledged byte is latched onto the port, and any later bytes are acknowledged but discarded. After a read address, the port is sampled at each acknowledge clock and shifted out MSB first. This continues for as long as the host acknowledges. Neighbouring logic receives a one-cycle write pulse while the new port value appears. It also receives a read pulse at each port sample and an acknowledge pulse at each target acknowledge.

Top module: `pexp_port_expander`

## Requirements
- R1: The address byte is taken MSB first, and its upper seven bits must equal 0,1,0,0 followed by the strap value (strap bit 2 first). Only then does the target pull SDA low for the ninth clock. Otherwise SDA stays released and the port is untouched.
- R2: An address byte of all zeros (general call) is never acknowledged.
- R3: When bit 0 of the address is 0, the first data byte is placed on `portOut` within a few system clocks after SCL rises in its acknowledge clock. `portWrStrobe` pulses for one cycle in the cycle the new value appears. After reset `portOut` is 0xFF and SDA is released.
- R4: A data byte cut short by a stop or a repeated start before its acknowledge leaves `portOut` unchanged.
- R5: Data bytes after the first one in a write transaction are acknowledged but never change `portOut` and raise no write pulse.
- R6: When bit 0 of the address is 1, the target sends the `portIn` value it sampled at the SCL rise of the preceding acknowledge clock, MSB first. Each such sample raises `portRdStrobe` for one cycle.
- R7: During a read, a host ACK (SDA low in the ninth clock) makes the target resample and send another byte. A host NACK makes the target release SDA until the next start or stop.
- R8: A start or repeated start seen at any bit position restarts address reception from bit 7.
- R9: The strap inputs are captured at each start condition. Changing them later in the transaction has no effect on the address match.
- R10: `ackStrobe` pulses once for every acknowledge the target drives, and SDA is held low while it pulses.
- R11: `sdaDriveLow` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| strapIn | input | 3 | Low three address bits set by straps |
| portIn | input | 8 | Sampled level of the port pins |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| portOut | output | 8 | Latched output value of the port |
| portWrStrobe | output | 1 | One-cycle pulse when `portOut` takes a new byte |
| portRdStrobe | output | 1 | One-cycle pulse when `portIn` is sampled for sending |
| ackStrobe | output | 1 | One-cycle pulse at each target acknowledge |

## Verification
The hardest conditions to reach are a data byte abandoned part-way, and a repeated start landing in the middle of the address byte. Neither happens in a well-formed transfer. The bench master is built from single-bit bus cycles, so it can issue a stop or a start after any number of bits and then confirm that the port has kept its old value. To make the read sampling point visible, the bench changes `portIn` right after each acknowledge clock and before the byte that follows. A byte that carries the old value proves the sample was taken at the acknowledge.

// File: rtl/pexp_pkg.sv
package pexp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // bus free or not addressed
    ST_ADDR,   // receiving the address byte
    ST_ACK,    // target drives the acknowledge
    ST_WRITE,  // receiving a data byte
    ST_READ,   // sending a port byte
    ST_MACK,   // host acknowledge slot after a sent byte
    ST_HOLD    // released, waiting for start or stop
  } busState_t;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic bitClear;
    logic bitInc;
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic portLoad;
    logic strapCapture;
  } dpCtl_t;

endpackage

// File: rtl/pexp_line_sync.sv
module pexp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic              sclPrev;
  logic              sdaPrev;
  logic              sclLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLevel  = sclPipe[STAGES-1];
  assign sdaLevel  = sdaPipe[STAGES-1];
  assign sclRise   = sclLevel & ~sclPrev;
  assign sclFall   = ~sclLevel & sclPrev;
  assign startSeen = sclLevel & sclPrev & sdaPrev & ~sdaLevel;
  assign stopSeen  = sclLevel & sclPrev & ~sdaPrev & sdaLevel;

endmodule

// File: rtl/pexp_datapath.sv
module pexp_datapath
  import pexp_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          STRAP_W   = 3,
  parameter logic [7:0]  RESET_VAL = 8'hFF,
  localparam int         CNT_W     = $clog2(BYTE_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic               sdaLevel,
  input  logic [BYTE_W-1:0]  portIn,
  input  logic [STRAP_W-1:0] strapIn,
  output logic [BYTE_W-1:0]  rxByte,
  output logic               txMsb,
  output logic [CNT_W-1:0]   bitCnt,
  output logic [STRAP_W-1:0] strapHeld,
  output logic [BYTE_W-1:0]  portOut
);

  logic [BYTE_W-1:0] rxReg;
  logic [BYTE_W-1:0] txReg;
  logic [BYTE_W-1:0] portReg;
  logic [CNT_W-1:0]  cntReg;
  logic [STRAP_W-1:0] strapReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg    <= '0;
      txReg    <= '1;
      portReg  <= RESET_VAL[BYTE_W-1:0];
      cntReg   <= '0;
      strapReg <= '0;
    end else begin
      if (ctl.bitClear)      cntReg <= '0;
      else if (ctl.bitInc)   cntReg <= cntReg + CNT_W'(1);

      if (ctl.rxShift)       rxReg <= {rxReg[BYTE_W-2:0], sdaLevel};

      if (ctl.txLoad)        txReg <= portIn;
      else if (ctl.txShift)  txReg <= {txReg[BYTE_W-2:0], 1'b1};

      if (ctl.strapCapture)  strapReg <= strapIn;
      if (ctl.portLoad)      portReg  <= rxReg;
    end
  end

  assign rxByte    = rxReg;
  assign txMsb     = txReg[BYTE_W-1];
  assign bitCnt    = cntReg;
  assign strapHeld = strapReg;
  assign portOut   = portReg;

endmodule

// File: rtl/pexp_ctrl.sv
module pexp_ctrl
  import pexp_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int STRAP_W = 3,
  parameter int PREFIX  = 4'b0100,
  localparam int CNT_W    = $clog2(BYTE_W + 1),
  localparam int PREFIX_W = BYTE_W - 1 - STRAP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               startSeen,
  input  logic               stopSeen,
  input  logic               sdaLevel,
  input  logic [BYTE_W-1:0]  rxByte,
  input  logic               txMsb,
  input  logic [CNT_W-1:0]   bitCnt,
  input  logic [STRAP_W-1:0] strapHeld,
  output dpCtl_t             ctl,
  output logic               sdaDriveLow,
  output logic               portWrStrobe,
  output logic               portRdStrobe,
  output logic               ackStrobe
);

  localparam logic [PREFIX_W-1:0] PREFIX_BITS = PREFIX[PREFIX_W-1:0];
  localparam logic [CNT_W-1:0]    FULL_CNT    = CNT_W'(BYTE_W);

  busState_t state;
  logic      isAddrAck;
  logic      readDir;
  logic      wrDone;
  logic      masterAck;
  logic      addrHit;
  logic      byteDone;
  logic      rxPhase;

  assign addrHit  = (rxByte[BYTE_W-1:1] == {PREFIX_BITS, strapHeld}) &&
                    (rxByte[BYTE_W-1:1] != '0);
  assign byteDone = (bitCnt == FULL_CNT);
  assign rxPhase  = (state == ST_ADDR) || (state == ST_WRITE);

  always_comb begin
    ctl              = '0;
    ctl.strapCapture = startSeen;
    ctl.bitClear     = startSeen ||
                       (sclFall && ((state == ST_ACK) || (state == ST_MACK)));
    ctl.bitInc       = sclRise && (rxPhase || (state == ST_READ)) && !byteDone;
    ctl.rxShift      = sclRise && rxPhase;
    ctl.txShift      = sclFall && (state == ST_READ) && !byteDone;
    ctl.portLoad     = sclRise && (state == ST_ACK) && !isAddrAck && !wrDone;
    ctl.txLoad       = sclRise && (((state == ST_ACK) && isAddrAck && readDir) ||
                                   ((state == ST_MACK) && !sdaLevel));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      isAddrAck    <= 1'b0;
      readDir      <= 1'b0;
      wrDone       <= 1'b0;
      masterAck    <= 1'b0;
      portWrStrobe <= 1'b0;
      portRdStrobe <= 1'b0;
      ackStrobe    <= 1'b0;
    end else begin
      portWrStrobe <= ctl.portLoad;
      portRdStrobe <= ctl.txLoad;
      ackStrobe    <= sclRise && (state == ST_ACK);

      if (stopSeen) begin
        state  <= ST_IDLE;
        wrDone <= 1'b0;
      end else if (startSeen) begin
        state     <= ST_ADDR;
        wrDone    <= 1'b0;
        isAddrAck <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (sclFall && byteDone) begin
              if (addrHit) begin
                state     <= ST_ACK;
                isAddrAck <= 1'b1;
                readDir   <= rxByte[0];
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_ACK: begin
            if (sclRise && !isAddrAck) wrDone <= 1'b1;
            if (sclFall) begin
              state     <= (isAddrAck && readDir) ? ST_READ : ST_WRITE;
              isAddrAck <= 1'b0;
            end
          end
          ST_WRITE: begin
            if (sclFall && byteDone) state <= ST_ACK;
          end
          ST_READ: begin
            if (sclFall && byteDone) state <= ST_MACK;
          end
          ST_MACK: begin
            if (sclRise) masterAck <= !sdaLevel;
            if (sclFall) state <= masterAck ? ST_READ : ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDriveLow = (state == ST_ACK) || ((state == ST_READ) && !txMsb);

endmodule

// File: rtl/pexp_port_expander.sv
module pexp_port_expander
  import pexp_pkg::*;
#(
  parameter int         BYTE_W      = 8,
  parameter int         STRAP_W     = 3,
  parameter int         PREFIX      = 4'b0100,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] RESET_VAL   = 8'hFF,
  localparam int        CNT_W       = $clog2(BYTE_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic [BYTE_W-1:0]  portIn,
  output logic               sdaDriveLow,
  output logic [BYTE_W-1:0]  portOut,
  output logic               portWrStrobe,
  output logic               portRdStrobe,
  output logic               ackStrobe
);

  logic               sdaLevel;
  logic               sclRise;
  logic               sclFall;
  logic               startSeen;
  logic               stopSeen;
  dpCtl_t             ctl;
  logic [BYTE_W-1:0]  rxByte;
  logic               txMsb;
  logic [CNT_W-1:0]   bitCnt;
  logic [STRAP_W-1:0] strapHeld;

  pexp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .sdaLevel  (sdaLevel),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startSeen (startSeen),
    .stopSeen  (stopSeen)
  );

  pexp_ctrl #(.BYTE_W(BYTE_W), .STRAP_W(STRAP_W), .PREFIX(PREFIX)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sclRise      (sclRise),
    .sclFall      (sclFall),
    .startSeen    (startSeen),
    .stopSeen     (stopSeen),
    .sdaLevel     (sdaLevel),
    .rxByte       (rxByte),
    .txMsb        (txMsb),
    .bitCnt       (bitCnt),
    .strapHeld    (strapHeld),
    .ctl          (ctl),
    .sdaDriveLow  (sdaDriveLow),
    .portWrStrobe (portWrStrobe),
    .portRdStrobe (portRdStrobe),
    .ackStrobe    (ackStrobe)
  );

  pexp_datapath #(.BYTE_W(BYTE_W), .STRAP_W(STRAP_W), .RESET_VAL(RESET_VAL)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sdaLevel  (sdaLevel),
    .portIn    (portIn),
    .strapIn   (strapIn),
    .rxByte    (rxByte),
    .txMsb     (txMsb),
    .bitCnt    (bitCnt),
    .strapHeld (strapHeld),
    .portOut   (portOut)
  );

endmodule

// File: rtl/pexp_checker.sv
module pexp_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaDriveLow,
  input logic [BYTE_W-1:0] portOut,
  input logic              portWrStrobe,
  input logic              portRdStrobe,
  input logic              ackStrobe
);

  // R3 R4 R5: the port only moves together with the write pulse
  a_r3_port_moves_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portOut) |-> portWrStrobe);

  // R10: the target holds SDA low while its acknowledge pulse is raised
  a_r10_ack_holds_sda: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |-> sdaDriveLow);

  // R3 R10: a port update always belongs to a target acknowledge
  a_r3_write_in_ack: assert property (@(posedge clk) disable iff (!rstN)
    portWrStrobe |-> ackStrobe);

  // R6: the read pulse lasts a single cycle
  a_r6_read_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    portRdStrobe |=> !portRdStrobe);

  // R11: SDA enable moves only while the bus clock is low
  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);

endmodule

bind pexp_port_expander pexp_checker #(.BYTE_W(BYTE_W)) u_pexpChk (
  .clk          (clk),
  .rstN         (rstN),
  .sclIn        (sclIn),
  .sdaDriveLow  (sdaDriveLow),
  .portOut      (portOut),
  .portWrStrobe (portWrStrobe),
  .portRdStrobe (portRdStrobe),
  .ackStrobe    (ackStrobe)
);

// File: tb/tb_pexp_port_expander.sv
module tb_pexp_port_expander;

  localparam int Q = 6;  // system clocks per quarter bus bit

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic [2:0] strap = 3'd0;
  logic [7:0] portInV = 8'h00;
  logic       sdaBus;
  logic       sdaDriveLow;
  logic [7:0] portOut;
  logic       portWrStrobe;
  logic       portRdStrobe;
  logic       ackStrobe;

  int nChecks = 0;
  int nFail = 0;
  int wrCount = 0;
  int rdCount = 0;
  int ackCount = 0;
  int sclViolations = 0;
  logic [7:0] wrLast = 8'h00;
  logic prevDrive = 1'b0;
  bit done = 1'b0;

  assign sdaBus = sdaM & ~sdaDriveLow;

  pexp_port_expander dut (
    .clk          (clk),
    .rstN         (rstN),
    .sclIn        (sclM),
    .sdaIn        (sdaBus),
    .strapIn      (strap),
    .portIn       (portInV),
    .sdaDriveLow  (sdaDriveLow),
    .portOut      (portOut),
    .portWrStrobe (portWrStrobe),
    .portRdStrobe (portRdStrobe),
    .ackStrobe    (ackStrobe)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rstN) begin
      if (portWrStrobe) begin wrCount++; wrLast = portOut; end
      if (portRdStrobe) rdCount++;
      if (ackStrobe) ackCount++;
      if ((sdaDriveLow !== prevDrive) && sclM) sclViolations++;
    end
    prevDrive = sdaDriveLow;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0;
  endtask

  task automatic busStop();
    tick(Q); sdaM = 1'b0;
    tick(Q); sclM = 1'b1;
    tick(Q); sdaM = 1'b1;
    tick(Q);
  endtask

  task automatic bitCycle(input logic b, output logic s);
    tick(Q); sdaM = b;
    tick(Q); sclM = 1'b1;
    tick(Q); s = sdaBus;
    tick(Q); sclM = 1'b0;
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) bitCycle(v[i], s);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic s;
    sendBits(v, 8);
    bitCycle(1'b1, s);
    sdaM = 1'b1;
    ack = ~s;
  endtask

  task automatic recvByte(input logic hostAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, s);
      v[i] = s;
    end
    bitCycle(~hostAck, s);
    sdaM = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] rd;
    logic [7:0] lastPort;
    int         wr0, ack0, rd0;

    tick(4);
    rstN = 1'b1;
    tick(4);
    // R3: reset state
    check("R3 reset port", portOut, 8'hFF);
    check("R3 reset sda released", sdaDriveLow, 1'b0);
    lastPort = 8'hFF;

    // R1 R3: sweep every strap value against every address low part
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        logic [7:0] dat;
        dat = 8'((s * 37 + a * 11) ^ 8'hA6);
        busStart();
        sendByte({4'b0100, 3'(a), 1'b0}, ack);
        check("R1 address match", ack, (a == s));
        if (ack) begin
          ack0 = ackCount;
          sendByte(dat, ack);
          check("R3 data acked", ack, 1'b1);
          check("R3 port value", portOut, dat);
          check("R3 write pulse value", wrLast, dat);
          check("R10 ack pulses", ackCount - ack0, 1);
          lastPort = dat;
        end else begin
          check("R1 mismatch leaves port", portOut, lastPort);
        end
        busStop();
      end
    end

    // R1: wrong prefix with matching strap bits
    strap = 3'd2;
    busStart();
    sendByte({4'b1100, 3'd2, 1'b0}, ack);
    check("R1 prefix mismatch", ack, 1'b0);
    busStop();

    // R2: general call never acknowledged, also with read bit
    strap = 3'd0;
    busStart();
    sendByte(8'h00, ack);
    check("R2 general call", ack, 1'b0);
    busStop();
    busStart();
    sendByte(8'h01, ack);
    check("R2 zero address read", ack, 1'b0);
    busStop();
    check("R2 port untouched", portOut, lastPort);

    // R5: further bytes acked but ignored
    strap = 3'd3;
    wr0 = wrCount;
    ack0 = ackCount;
    busStart();
    sendByte({4'b0100, 3'd3, 1'b0}, ack);
    sendByte(8'h5A, ack);
    check("R5 first byte", portOut, 8'h5A);
    sendByte(8'hC3, ack);
    check("R5 extra byte acked", ack, 1'b1);
    sendByte(8'h11, ack);
    busStop();
    check("R5 port keeps first", portOut, 8'h5A);
    check("R5 single write pulse", wrCount - wr0, 1);
    check("R10 ack count four", ackCount - ack0, 4);

    // R4: byte cut by stop
    busStart();
    sendByte({4'b0100, 3'd3, 1'b0}, ack);
    sendBits(8'h0F, 5);
    busStop();
    check("R4 stop mid byte", portOut, 8'h5A);
    // R4: byte cut by repeated start, then a fresh write works
    busStart();
    sendByte({4'b0100, 3'd3, 1'b0}, ack);
    sendBits(8'h96, 7);
    busStart();
    check("R4 repeated start mid byte", portOut, 8'h5A);
    sendByte({4'b0100, 3'd3, 1'b0}, ack);
    check("R8 ack after repeated start", ack, 1'b1);
    sendByte(8'h3C, ack);
    busStop();
    check("R8 write after restart", portOut, 8'h3C);

    // R8: repeated start inside the address byte
    busStart();
    sendBits(8'hFF, 3);
    busStart();
    sendByte({4'b0100, 3'd3, 1'b0}, ack);
    check("R8 restart in address", ack, 1'b1);
    sendByte(8'hE7, ack);
    busStop();
    check("R8 port after restart", portOut, 8'hE7);

    // R9: strap captured at start
    strap = 3'd2;
    busStart();
    strap = 3'd5;
    sendByte({4'b0100, 3'd2, 1'b0}, ack);
    check("R9 strap held from start", ack, 1'b1);
    busStop();
    busStart();
    sendByte({4'b0100, 3'd5, 1'b0}, ack);
    check("R9 new strap after start", ack, 1'b1);
    busStop();

    // R6 R7: read with resample on host ACK, release on NACK
    strap = 3'd6;
    portInV = 8'hA5;
    rd0 = rdCount;
    busStart();
    sendByte({4'b0100, 3'd6, 1'b1}, ack);
    check("R6 read address acked", ack, 1'b1);
    portInV = 8'h3C;
    recvByte(1'b1, rd);
    check("R6 sample at address ack", rd, 8'hA5);
    portInV = 8'h77;
    recvByte(1'b0, rd);
    check("R7 resample on host ack", rd, 8'h3C);
    recvByte(1'b0, rd);
    check("R7 released after nack", rd, 8'hFF);
    busStop();
    check("R6 read pulses", rdCount - rd0, 2);

    // R6: sweep of port patterns
    for (int k = 0; k < 16; k++) begin
      logic [7:0] pat;
      pat = 8'((k * 29) ^ 8'h5A);
      portInV = pat;
      busStart();
      sendByte({4'b0100, 3'd6, 1'b1}, ack);
      portInV = ~pat;
      recvByte(1'b0, rd);
      busStop();
      check("R6 read pattern", rd, pat);
    end

    check("R11 sda changes with scl low", sclViolations, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule